// File: doc/BRIEF.md
# Non-Posted Request Handling Controller

This block sits in the request path of a two-port bus bridge. Each request arrives already decoded: a command code, whether it is aimed at the bridge's own configuration space, which side it came from, and whether the originating bus runs in the split-capable mode. From these inputs the block picks one of four handlings. It can pass the request on untouched, complete it at once against a small local configuration store, forward it as a delayed transaction, or forward it as a split transaction.

Delayed and split requests share a single pending entry. A delayed request is first retried. It is then issued on the destination side, and it finishes when the originator tries again with the same command, address and byte enables. A split request gets a split response straight away, and a completion pulse follows once the destination has answered. Destination error status is carried back in both cases. Any deferred request that arrives while the entry is busy is retried.

Top module: `nonposted_txn_ctrl`

## Requirements
- R1: Command codes are IO read 0, IO write 1, memory read 2, memory read line 3, memory read multiple 4, memory read DWORD 5, memory read block 6, type-0 config read 7, type-0 config write 8, type-1 config read 9, type-1 config write 10. Response codes on `rsp_kind` are none 0, retry 1, immediate 2, split 3, done 4, bypass 5. A code 7 or 8 request from the primary side (`req_side`=0) with `req_to_bridge`=1 gets response 2 in the cycle after it is sampled, and it raises no destination request.
- R2: An immediate config write updates the local word selected by `req_addr[3:2]`, only in the bytes whose byte-enable bit is set. An immediate config read returns that word on `rsp_rdata`.
- R3: In conventional mode (`req_split_mode`=0), every deferred command is handled as delayed. Commands 2, 3 and 4 are delayed in either mode. A delayed request that finds the entry free gets response 1, and from the next cycle `dst_req_valid` is high carrying its command, address and byte enables.
- R4: In split mode, deferred commands other than 2, 3 and 4 get response 3 and are issued to the destination. When `dst_done` is sampled, `cpl_valid` pulses for exactly one cycle on the next cycle and the entry is freed.
- R5: While `dst_req_valid` is high and `dst_done` has not been sampled, the request stays high and its command, address and byte enables do not change.
- R6: After a delayed request's destination result is back, a re-attempt with an equal command, address and byte enables gets response 4 with the returned read data, and the entry is freed.
- R7: A deferred request that arrives while the entry is busy gets response 1 and leaves the entry unchanged. This covers every case except a matching re-attempt after the result is back.
- R8: The destination error flag is returned on `rsp_err` with a delayed completion and on `cpl_err` with a split completion.
- R9: Codes 7 and 8 coming from the secondary side, or not aimed at the bridge, are deferred like any other forwarded command.
- R10: Codes 11 to 15 get response 5 and do not touch the entry or the configuration store.
- R11: After reset, `rsp_kind` is 0, `dst_req_valid` and `cpl_valid` are low, and every configuration word reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_cmd | input | 4 | Command code |
| req_side | input | 1 | 0 primary, 1 secondary |
| req_to_bridge | input | 1 | Request targets the bridge itself |
| req_split_mode | input | 1 | Originating bus is in split-capable mode |
| req_addr | input | AW | Request address |
| req_be | input | 4 | Byte enables |
| req_wdata | input | 32 | Write DWORD |
| rsp_kind | output | 3 | Response code to the originator |
| rsp_err | output | 1 | Error status with a done response |
| rsp_rdata | output | 32 | Read data with immediate or done response |
| dst_req_valid | output | 1 | Request to the destination side |
| dst_cmd | output | 4 | Forwarded command |
| dst_addr | output | AW | Forwarded address |
| dst_be | output | 4 | Forwarded byte enables |
| dst_wdata | output | 32 | Forwarded write DWORD |
| dst_done | input | 1 | Destination finished the request |
| dst_err | input | 1 | Destination error status |
| dst_rdata | input | 32 | Destination read data |
| cpl_valid | output | 1 | Split completion pulse |
| cpl_err | output | 1 | Split completion error status |
| cpl_rdata | output | 32 | Split completion read data |

## Verification
The assertions assume at most one request per cycle. They also assume `dst_done` is raised only while `dst_req_valid` is high, and that the mode and side flags describe the request they arrive with. The bench drives each request for a single cycle. It raises `dst_done` only after it has seen the destination request, and it lowers `dst_done` on the next cycle. Every command, side, target and mode combination is swept starting from a free entry, so each request's handling is classified against a known idle state.

// File: rtl/nptc_pkg.sv
package nptc_pkg;

    localparam int DWORD_W = 32;
    localparam int BE_W    = 4;
    localparam int CMD_W   = 4;

    typedef enum logic [CMD_W-1:0] {
        CMD_IO_RD       = 4'd0,
        CMD_IO_WR       = 4'd1,
        CMD_MEM_RD      = 4'd2,
        CMD_MEM_RD_LINE = 4'd3,
        CMD_MEM_RD_MULT = 4'd4,
        CMD_MEM_RD_DW   = 4'd5,
        CMD_MEM_RD_BLK  = 4'd6,
        CMD_CFG0_RD     = 4'd7,
        CMD_CFG0_WR     = 4'd8,
        CMD_CFG1_RD     = 4'd9,
        CMD_CFG1_WR     = 4'd10
    } cmd_e;

    typedef enum logic [2:0] {
        RSP_NONE   = 3'd0,
        RSP_RETRY  = 3'd1,
        RSP_IMM    = 3'd2,
        RSP_SPLIT  = 3'd3,
        RSP_DONE   = 3'd4,
        RSP_BYPASS = 3'd5
    } rsp_e;

    typedef enum logic [1:0] {
        H_BYPASS  = 2'd0,
        H_IMM     = 2'd1,
        H_DELAYED = 2'd2,
        H_SPLIT   = 2'd3
    } handling_e;

    typedef enum logic [1:0] {
        SLOT_IDLE  = 2'd0,
        SLOT_ISSUE = 2'd1,
        SLOT_HELD  = 2'd2
    } slot_state_e;

    typedef struct packed {
        logic [CMD_W-1:0]   cmd;
        logic [BE_W-1:0]    be;
        logic [DWORD_W-1:0] wdata;
    } entry_t;

    typedef struct packed {
        logic               err;
        logic [DWORD_W-1:0] data;
    } result_t;

    function automatic logic cmd_known(input logic [CMD_W-1:0] c);
        return c <= CMD_CFG1_WR;
    endfunction

    function automatic logic cmd_cfg0(input logic [CMD_W-1:0] c);
        return (c == CMD_CFG0_RD) || (c == CMD_CFG0_WR);
    endfunction

    function automatic logic cmd_always_delayed(input logic [CMD_W-1:0] c);
        return (c == CMD_MEM_RD) || (c == CMD_MEM_RD_LINE) || (c == CMD_MEM_RD_MULT);
    endfunction

    function automatic logic [DWORD_W-1:0] merge_bytes(
        input logic [DWORD_W-1:0] old_w,
        input logic [DWORD_W-1:0] new_w,
        input logic [BE_W-1:0]    be
    );
        logic [DWORD_W-1:0] r;
        r = old_w;
        for (int b = 0; b < BE_W; b++) begin
            if (be[b]) r[8*b +: 8] = new_w[8*b +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/nptc_classify.sv
module nptc_classify
    import nptc_pkg::*;
(
    input  logic [CMD_W-1:0] cmd,
    input  logic             side,
    input  logic             to_bridge,
    input  logic             split_mode,
    output handling_e        handling
);
    always_comb begin
        if (!cmd_known(cmd)) begin
            handling = H_BYPASS;
        end else if (cmd_cfg0(cmd) && !side && to_bridge) begin
            handling = H_IMM;
        end else if (split_mode && !cmd_always_delayed(cmd)) begin
            handling = H_SPLIT;
        end else begin
            handling = H_DELAYED;
        end
    end
endmodule

// File: rtl/nptc_cfg_regs.sv
module nptc_cfg_regs
    import nptc_pkg::*;
#(
    parameter int WORDS = 4,
    localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   idx,
    input  logic [BE_W-1:0]    be,
    input  logic [DWORD_W-1:0] wdata,
    output logic [DWORD_W-1:0] rdata
);
    logic [DWORD_W-1:0] word_q [WORDS];

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                word_q[g] <= '0;
            end else if (wr_en && (idx == IDX_W'(g))) begin
                word_q[g] <= merge_bytes(word_q[g], wdata, be);
            end
        end
    end

    assign rdata = word_q[idx];
endmodule

// File: rtl/nptc_slot.sv
module nptc_slot
    import nptc_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               take,
    input  logic               take_split,
    input  logic [AW-1:0]      cap_addr,
    input  entry_t             cap_entry,
    input  logic [CMD_W-1:0]   probe_cmd,
    input  logic [AW-1:0]      probe_addr,
    input  logic [BE_W-1:0]    probe_be,
    input  logic               release_i,
    input  logic               dst_done,
    input  logic               dst_err,
    input  logic [DWORD_W-1:0] dst_rdata,
    output slot_state_e        state,
    output logic               hit,
    output entry_t             entry,
    output logic [AW-1:0]      addr,
    output result_t            result,
    output logic               cpl_valid,
    output result_t            cpl_result
);
    slot_state_e state_q;
    logic        split_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= SLOT_IDLE;
            split_q    <= 1'b0;
            entry      <= '0;
            addr       <= '0;
            result     <= '0;
            cpl_valid  <= 1'b0;
            cpl_result <= '0;
        end else begin
            cpl_valid <= 1'b0;
            case (state_q)
                SLOT_IDLE: begin
                    if (take) begin
                        state_q <= SLOT_ISSUE;
                        split_q <= take_split;
                        entry   <= cap_entry;
                        addr    <= cap_addr;
                    end
                end
                SLOT_ISSUE: begin
                    if (dst_done) begin
                        if (split_q) begin
                            state_q    <= SLOT_IDLE;
                            cpl_valid  <= 1'b1;
                            cpl_result <= '{err: dst_err, data: dst_rdata};
                        end else begin
                            state_q <= SLOT_HELD;
                            result  <= '{err: dst_err, data: dst_rdata};
                        end
                    end
                end
                SLOT_HELD: begin
                    if (release_i) state_q <= SLOT_IDLE;
                end
                default: state_q <= SLOT_IDLE;
            endcase
        end
    end

    assign state = state_q;
    assign hit   = (probe_cmd == entry.cmd) && (probe_addr == addr) && (probe_be == entry.be);
endmodule

// File: rtl/nonposted_txn_ctrl.sv
module nonposted_txn_ctrl
    import nptc_pkg::*;
#(
    parameter int AW        = 16,
    parameter int CFG_WORDS = 4,
    localparam int CFG_IDX_W = (CFG_WORDS > 1) ? $clog2(CFG_WORDS) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [3:0]         req_cmd,
    input  logic               req_side,
    input  logic               req_to_bridge,
    input  logic               req_split_mode,
    input  logic [AW-1:0]      req_addr,
    input  logic [3:0]         req_be,
    input  logic [31:0]        req_wdata,
    output logic [2:0]         rsp_kind,
    output logic               rsp_err,
    output logic [31:0]        rsp_rdata,
    output logic               dst_req_valid,
    output logic [3:0]         dst_cmd,
    output logic [AW-1:0]      dst_addr,
    output logic [3:0]         dst_be,
    output logic [31:0]        dst_wdata,
    input  logic               dst_done,
    input  logic               dst_err,
    input  logic [31:0]        dst_rdata,
    output logic               cpl_valid,
    output logic               cpl_err,
    output logic [31:0]        cpl_rdata
);
    handling_e   handling;
    slot_state_e slot_state;
    logic        slot_hit;
    entry_t      slot_entry;
    result_t     slot_result;
    result_t     slot_cpl;
    logic        take, take_split, release_entry, cfg_we;
    logic [DWORD_W-1:0] cfg_rdata;
    rsp_e        kind_n;
    logic        err_n;
    logic [DWORD_W-1:0] data_n;

    nptc_classify u_classify (
        .cmd        (req_cmd),
        .side       (req_side),
        .to_bridge  (req_to_bridge),
        .split_mode (req_split_mode),
        .handling   (handling)
    );

    nptc_cfg_regs #(.WORDS(CFG_WORDS)) u_cfg (
        .clk   (clk),
        .rst   (rst),
        .wr_en (cfg_we),
        .idx   (req_addr[2 +: CFG_IDX_W]),
        .be    (req_be),
        .wdata (req_wdata),
        .rdata (cfg_rdata)
    );

    nptc_slot #(.AW(AW)) u_slot (
        .clk        (clk),
        .rst        (rst),
        .take       (take),
        .take_split (take_split),
        .cap_addr   (req_addr),
        .cap_entry  ('{cmd: req_cmd, be: req_be, wdata: req_wdata}),
        .probe_cmd  (req_cmd),
        .probe_addr (req_addr),
        .probe_be   (req_be),
        .release_i  (release_entry),
        .dst_done   (dst_done),
        .dst_err    (dst_err),
        .dst_rdata  (dst_rdata),
        .state      (slot_state),
        .hit        (slot_hit),
        .entry      (slot_entry),
        .addr       (dst_addr),
        .result     (slot_result),
        .cpl_valid  (cpl_valid),
        .cpl_result (slot_cpl)
    );

    always_comb begin
        take          = 1'b0;
        take_split    = 1'b0;
        release_entry = 1'b0;
        cfg_we        = 1'b0;
        kind_n        = RSP_NONE;
        err_n         = 1'b0;
        data_n        = '0;
        if (req_valid) begin
            case (handling)
                H_BYPASS: kind_n = RSP_BYPASS;
                H_IMM: begin
                    kind_n = RSP_IMM;
                    if (req_cmd == CMD_CFG0_WR) cfg_we = 1'b1;
                    else                        data_n = cfg_rdata;
                end
                default: begin
                    if (slot_state == SLOT_IDLE) begin
                        take       = 1'b1;
                        take_split = (handling == H_SPLIT);
                        kind_n     = (handling == H_SPLIT) ? RSP_SPLIT : RSP_RETRY;
                    end else if (slot_state == SLOT_HELD && slot_hit) begin
                        release_entry = 1'b1;
                        kind_n        = RSP_DONE;
                        err_n         = slot_result.err;
                        data_n        = slot_result.data;
                    end else begin
                        kind_n = RSP_RETRY;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_kind  <= RSP_NONE;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_kind  <= kind_n;
            rsp_err   <= err_n;
            rsp_rdata <= data_n;
        end
    end

    assign dst_req_valid = (slot_state == SLOT_ISSUE);
    assign dst_cmd       = slot_entry.cmd;
    assign dst_be        = slot_entry.be;
    assign dst_wdata     = slot_entry.wdata;
    assign cpl_err       = slot_cpl.err;
    assign cpl_rdata     = slot_cpl.data;
endmodule

// File: rtl/nptc_checker.sv
module nptc_checker #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          req_valid,
    input logic [3:0]    req_cmd,
    input logic          req_side,
    input logic          req_to_bridge,
    input logic [2:0]    rsp_kind,
    input logic          dst_req_valid,
    input logic [3:0]    dst_cmd,
    input logic [AW-1:0] dst_addr,
    input logic [3:0]    dst_be,
    input logic          dst_done,
    input logic          cpl_valid
);
    logic imm_req, known_req;
    assign imm_req   = ((req_cmd == 4'd7) || (req_cmd == 4'd8)) && !req_side && req_to_bridge;
    assign known_req = (req_cmd <= 4'd10);

    p_imm_rsp_r1: assert property (@(posedge clk) disable iff (rst)
        req_valid && imm_req |=> rsp_kind == 3'd2);

    p_cpl_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        cpl_valid |=> !cpl_valid);

    p_dst_hold_r5: assert property (@(posedge clk) disable iff (rst)
        dst_req_valid && !dst_done |=> dst_req_valid && $stable(dst_cmd)
                                       && $stable(dst_addr) && $stable(dst_be));

    p_done_frees_r6: assert property (@(posedge clk) disable iff (rst)
        rsp_kind == 3'd4 |-> !dst_req_valid);

    p_busy_retry_r7: assert property (@(posedge clk) disable iff (rst)
        req_valid && known_req && !imm_req && dst_req_valid |=> rsp_kind == 3'd1);

    p_bypass_r10: assert property (@(posedge clk) disable iff (rst)
        req_valid && !known_req |=> rsp_kind == 3'd5);
endmodule

bind nonposted_txn_ctrl nptc_checker #(.AW(AW)) u_nptc_checker (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_cmd       (req_cmd),
    .req_side      (req_side),
    .req_to_bridge (req_to_bridge),
    .rsp_kind      (rsp_kind),
    .dst_req_valid (dst_req_valid),
    .dst_cmd       (dst_cmd),
    .dst_addr      (dst_addr),
    .dst_be        (dst_be),
    .dst_done      (dst_done),
    .cpl_valid     (cpl_valid)
);

// File: tb/nonposted_txn_ctrl_bench.sv
`timescale 1ns/1ps
module nonposted_txn_ctrl_bench;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [3:0]    req_cmd = '0;
    logic          req_side = 1'b0;
    logic          req_to_bridge = 1'b0;
    logic          req_split_mode = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [3:0]    req_be = '0;
    logic [31:0]   req_wdata = '0;
    logic [2:0]    rsp_kind;
    logic          rsp_err;
    logic [31:0]   rsp_rdata;
    logic          dst_req_valid;
    logic [3:0]    dst_cmd;
    logic [AW-1:0] dst_addr;
    logic [3:0]    dst_be;
    logic [31:0]   dst_wdata;
    logic          dst_done = 1'b0;
    logic          dst_err = 1'b0;
    logic [31:0]   dst_rdata = '0;
    logic          cpl_valid;
    logic          cpl_err;
    logic [31:0]   cpl_rdata;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    logic [31:0] cfg_model [4];

    always #10 clk = ~clk;

    nonposted_txn_ctrl #(.AW(AW), .CFG_WORDS(4)) u_nonposted_txn_ctrl (.*);

    task automatic check(input logic ok, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", what, act, exp);
        end
    endtask

    function automatic logic [2:0] exp_kind(input logic [3:0] c, input logic s,
                                            input logic t, input logic m);
        if (c > 4'd10) return 3'd5;
        if ((c == 4'd7 || c == 4'd8) && !s && t) return 3'd2;
        if (m && !(c == 4'd2 || c == 4'd3 || c == 4'd4)) return 3'd3;
        return 3'd1;
    endfunction

    function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] n,
                                          input logic [3:0] be);
        logic [31:0] r = o;
        for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = n[8*b +: 8];
        return r;
    endfunction

    task automatic send(input logic [3:0] c, input logic s, input logic t, input logic m,
                        input logic [AW-1:0] a, input logic [3:0] be, input logic [31:0] wd);
        @(negedge clk);
        req_valid = 1'b1; req_cmd = c; req_side = s; req_to_bridge = t;
        req_split_mode = m; req_addr = a; req_be = be; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic reply(input logic e, input logic [31:0] d);
        @(negedge clk);
        dst_done = 1'b1; dst_err = e; dst_rdata = d;
        @(negedge clk);
        dst_done = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles == 100000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below 100000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) cfg_model[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        check(rsp_kind == 3'd0, "R11 rsp_kind after reset", 32'(rsp_kind), 0);
        check(!dst_req_valid, "R11 dst_req_valid after reset", 32'(dst_req_valid), 0);
        check(!cpl_valid, "R11 cpl_valid after reset", 32'(cpl_valid), 0);
        for (int w = 0; w < 4; w++) begin
            send(4'd7, 1'b0, 1'b1, 1'b0, AW'(w*4), 4'hF, 0);
            check(rsp_rdata == 0, "R11 config word zero", rsp_rdata, 0);
        end

        // R2 byte-enable merge
        send(4'd8, 1'b0, 1'b1, 1'b0, AW'(4), 4'hF, 32'hFFFF_FFFF);
        cfg_model[1] = 32'hFFFF_FFFF;
        send(4'd8, 1'b0, 1'b1, 1'b0, AW'(4), 4'b0101, 32'h0);
        cfg_model[1] = merge(cfg_model[1], 0, 4'b0101);
        send(4'd7, 1'b0, 1'b1, 1'b0, AW'(4), 4'hF, 0);
        check(rsp_rdata == 32'hFF00_FF00, "R2 partial byte write", rsp_rdata, 32'hFF00_FF00);

        // Sweep over command, side, target and mode
        for (int idx = 0; idx < 128; idx++) begin
            logic [3:0]    c;
            logic          s, t, m, e;
            logic [2:0]    ek;
            logic [AW-1:0] a;
            logic [3:0]    be;
            logic [31:0]   wd, rd;
            c  = 4'(idx >> 3);
            s  = idx[2]; t = idx[1]; m = idx[0];
            a  = AW'(16'h1000 + idx*4);
            be = 4'((idx % 15) + 1);
            wd = 32'hA500_0000 | 32'(idx);
            rd = 32'hD000_0000 + 32'(idx);
            e  = idx[0] ^ idx[3];
            ek = exp_kind(c, s, t, m);
            send(c, s, t, m, a, be, wd);
            check(rsp_kind == ek, "R1 R3 R4 R9 R10 handling", 32'(rsp_kind), 32'(ek));
            if (ek == 3'd5 || ek == 3'd2) begin
                check(!dst_req_valid, "R1 R10 no destination request", 32'(dst_req_valid), 0);
                if (ek == 3'd2) begin
                    if (c == 4'd8) cfg_model[a[3:2]] = merge(cfg_model[a[3:2]], wd, be);
                    else check(rsp_rdata == cfg_model[a[3:2]], "R2 immediate read",
                               rsp_rdata, cfg_model[a[3:2]]);
                end
            end else begin
                check(dst_req_valid && dst_cmd == c && dst_addr == a && dst_be == be
                      && dst_wdata == wd, "R3 destination request", 32'(dst_addr), 32'(a));
                send(c, s, t, m, a, be, wd);
                check(rsp_kind == 3'd1, "R7 retry while issuing", 32'(rsp_kind), 1);
                check(dst_req_valid && dst_addr == a, "R5 request held", 32'(dst_addr), 32'(a));
                reply(e, rd);
                if (ek == 3'd3) begin
                    check(cpl_valid && cpl_err == e && cpl_rdata == rd,
                          "R4 R8 split completion", cpl_rdata, rd);
                    check(!dst_req_valid, "R4 entry freed", 32'(dst_req_valid), 0);
                    @(negedge clk);
                    check(!cpl_valid, "R4 single pulse", 32'(cpl_valid), 0);
                end else begin
                    check(!cpl_valid && !dst_req_valid, "R3 result held",
                          32'(cpl_valid), 0);
                    send(c, s, t, m, a ^ AW'(4), be, wd);
                    check(rsp_kind == 3'd1, "R7 address mismatch retried", 32'(rsp_kind), 1);
                    send(c, s, t, m, a, be ^ 4'h1, wd);
                    check(rsp_kind == 3'd1, "R7 byte enable mismatch retried", 32'(rsp_kind), 1);
                    send(c, s, t, m, a, be, wd);
                    check(rsp_kind == 3'd4 && rsp_rdata == rd, "R6 done on re-attempt",
                          rsp_rdata, rd);
                    check(rsp_err == e, "R8 error returned", 32'(rsp_err), 32'(e));
                end
            end
        end

        // Immediate and bypass requests while the entry is busy
        send(4'd0, 1'b0, 1'b0, 1'b0, AW'(16'h2000), 4'hF, 0);
        check(rsp_kind == 3'd1 && dst_req_valid, "R3 IO read deferred", 32'(rsp_kind), 1);
        send(4'd8, 1'b0, 1'b1, 1'b0, AW'(12), 4'hF, 32'h1234_5678);
        check(rsp_kind == 3'd2, "R1 immediate while busy", 32'(rsp_kind), 2);
        send(4'd12, 1'b0, 1'b0, 1'b0, AW'(16'h3000), 4'h3, 0);
        check(rsp_kind == 3'd5, "R10 bypass while busy", 32'(rsp_kind), 5);
        check(dst_req_valid && dst_addr == AW'(16'h2000) && dst_cmd == 4'd0,
              "R10 entry untouched", 32'(dst_addr), 32'h2000);
        send(4'd7, 1'b0, 1'b1, 1'b0, AW'(12), 4'hF, 0);
        check(rsp_rdata == 32'h1234_5678, "R2 read back while busy", rsp_rdata, 32'h1234_5678);
        send(4'd9, 1'b1, 1'b0, 1'b1, AW'(16'h4000), 4'hF, 0);
        check(rsp_kind == 3'd1, "R7 other request retried", 32'(rsp_kind), 1);
        reply(1'b0, 32'hCAFE_0001);
        send(4'd0, 1'b0, 1'b0, 1'b0, AW'(16'h2000), 4'hF, 0);
        check(rsp_kind == 3'd4 && rsp_rdata == 32'hCAFE_0001, "R6 directed completion",
              rsp_rdata, 32'hCAFE_0001);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule